// File: doc/BRIEF.md
# Line-Alternate Chroma Blanking Controller

This block post-processes two demodulated colour-difference sample streams and presents them as negated outputs, -(R-Y) and -(B-Y). A half-line-rate phase state machine changes phase at every line start. The current phase steers two things. In the phase-alternating standard it sets the sign of the R-Y path through the line-alternating switch. In the sequential-colour standard it sets which output channel receives the single demodulated stream, while the other channel is held at the black level. In both NTSC variants the switch stays off and both streams pass straight through.

Three conditions force both outputs to the black level in every standard: horizontal flyback, combined horizontal/vertical flyback, and a colour-kill request when no standard has been identified. The identification logic may find that the line alternation runs out of step. It then raises a phase-error flag. The state machine records this as a pending fix, and at the next line start it holds its phase rather than toggling, which brings the alternation back into step.

The state machine has four states. `PH_RY` is an R-Y line with no fix pending. `PH_BY` is a B-Y line with no fix pending. `PH_RY_FIX` and `PH_BY_FIX` are the same two lines with a fix pending. There are three kinds of transition. A plain toggle goes between `PH_RY` and `PH_BY` at a line start. An arm moves to the matching fix state when phase_err is seen mid-line. A slip leaves a fix state at a line start while keeping the same line phase.

Top module: `chroma_alt_blank`

## Requirements
- R1: While rst_n is low, out_ry, out_by and out_valid are 0 and pal_invert is 0. After reset, the phase is the R-Y line phase, and colour stays killed until colour_en is high.
- R2: Each line_start pulse without a pending fix toggles the line phase at that clock edge. A sample in the same cycle as the line_start still uses the old phase. Between line starts, the phase does not change.
- R3: phase_err arms a fix. At the next line_start the phase is held instead of toggled, and the fix is then cleared. Further phase_err pulses within the same line have no additional effect. A phase_err in the same cycle as a line_start arms a fix for the new line.
- R4: When std_mode = 2'b01 (sequential colour), the single stream enters on in_ry and in_by is ignored. On an R-Y line, out_ry = -in_ry and out_by = 0. On a B-Y line, out_by = -in_ry and out_ry = 0.
- R5: When std_mode = 2'b00 (phase alternating), out_by = -in_by. On an R-Y line, out_ry = -in_ry. On a B-Y line, out_ry = +in_ry, and pal_invert is 1.
- R6: When std_mode = 2'b10 or 2'b11 (NTSC 3.58 / 4.43), out_ry = -in_ry and out_by = -in_by on every line, and pal_invert is 0.
- R7: A sample taken with hblank or hvblank high gives out_ry = out_by = 0 (black) in every mode.
- R8: A sample taken with colour_en low gives out_ry = out_by = 0.
- R9: Negation saturates. The most negative input code gives the most positive output code.
- R10: Outputs are registered. A sample with smp_valid high appears one clock later with out_valid high. When smp_valid is low, out_valid goes low and out_ry and out_by hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Input sample qualifier |
| line_start | input | 1 | One-cycle pulse at each line start |
| hblank | input | 1 | Horizontal flyback blanking |
| hvblank | input | 1 | Combined horizontal/vertical flyback blanking |
| std_mode | input | 2 | 00 phase-alternating, 01 sequential, 10 NTSC 3.58, 11 NTSC 4.43 |
| colour_en | input | 1 | Standard identified; low kills colour |
| phase_err | input | 1 | Identification found line alternation out of step |
| in_ry | input | DATA_W | Signed R-Y sample (sequential stream in mode 01) |
| in_by | input | DATA_W | Signed B-Y sample |
| out_ry | output | DATA_W | Signed -(R-Y) output |
| out_by | output | DATA_W | Signed -(B-Y) output |
| out_valid | output | 1 | Output sample qualifier |
| pal_invert | output | 1 | Line-alternating switch state (1 = R-Y inverted) |

## Verification
The bench builds the block with DATA_W = 8. This puts the saturation corner, -128 turning into +127, within reach of a short vector table. It also makes the unsaturated pass-through of -128 on inverted lines visible. At that width, the full set of mode and phase combinations, together with the slip sequences of the fix state machine, can be exercised in a few dozen cycles.

// File: rtl/chroma_alt_pkg.sv
package chroma_alt_pkg;

    typedef enum logic [1:0] {
        STD_PAL      = 2'b00,
        STD_SECAM    = 2'b01,
        STD_NTSC_358 = 2'b10,
        STD_NTSC_443 = 2'b11
    } chroma_std_e;

    typedef enum logic [1:0] {
        PH_RY     = 2'b00,
        PH_BY     = 2'b01,
        PH_RY_FIX = 2'b10,
        PH_BY_FIX = 2'b11
    } h2_state_e;

endpackage

// File: rtl/h2_phase_fsm.sv
module h2_phase_fsm
    import chroma_alt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic phase_err,
    output logic by_line,
    output logic fix_pending
);

    h2_state_e state_q;
    h2_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_RY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RY: begin
                if (line_start)     state_d = phase_err ? PH_BY_FIX : PH_BY;
                else if (phase_err) state_d = PH_RY_FIX;
            end
            PH_BY: begin
                if (line_start)     state_d = phase_err ? PH_RY_FIX : PH_RY;
                else if (phase_err) state_d = PH_BY_FIX;
            end
            PH_RY_FIX: begin
                if (line_start)     state_d = phase_err ? PH_RY_FIX : PH_RY;
            end
            PH_BY_FIX: begin
                if (line_start)     state_d = phase_err ? PH_BY_FIX : PH_BY;
            end
            default: state_d = PH_RY;
        endcase
    end

    always_comb begin
        by_line     = 1'b0;
        fix_pending = 1'b0;
        unique case (state_q)
            PH_RY:     begin by_line = 1'b0; fix_pending = 1'b0; end
            PH_BY:     begin by_line = 1'b1; fix_pending = 1'b0; end
            PH_RY_FIX: begin by_line = 1'b0; fix_pending = 1'b1; end
            PH_BY_FIX: begin by_line = 1'b1; fix_pending = 1'b1; end
            default:   begin by_line = 1'b0; fix_pending = 1'b0; end
        endcase
    end

    // R2: a line start with no pending fix flips the phase
    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !fix_pending) |=> (by_line != $past(by_line)));

    // R2: the phase only moves at a line start
    p_hold_midline_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(by_line));

    // R3: a pending fix makes the next line start keep the phase
    p_slip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && fix_pending) |=> (by_line == $past(by_line)));

    // R3: a fix stays armed until a line start consumes it
    p_fix_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_pending && !line_start) |=> fix_pending);

endmodule

// File: rtl/chroma_route.sv
module chroma_route
    import chroma_alt_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic [1:0]               std_mode,
    input  logic                     by_line,
    input  logic signed [DATA_W-1:0] in_ry,
    input  logic signed [DATA_W-1:0] in_by,
    output logic signed [DATA_W-1:0] rt_ry,
    output logic signed [DATA_W-1:0] rt_by,
    output logic                     pal_invert
);

    localparam logic signed [DATA_W-1:0] MAX_CODE = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] BLACK    = '0;

    function automatic logic signed [DATA_W-1:0] sat_neg(input logic signed [DATA_W-1:0] v);
        if (v == MIN_CODE) return MAX_CODE;
        return -v;
    endfunction

    chroma_std_e std;
    assign std = chroma_std_e'(std_mode);

    always_comb begin
        rt_ry      = BLACK;
        rt_by      = BLACK;
        pal_invert = 1'b0;
        unique case (std)
            STD_PAL: begin
                pal_invert = by_line;
                rt_ry      = by_line ? in_ry : sat_neg(in_ry);
                rt_by      = sat_neg(in_by);
            end
            STD_SECAM: begin
                rt_ry = by_line ? BLACK : sat_neg(in_ry);
                rt_by = by_line ? sat_neg(in_ry) : BLACK;
            end
            STD_NTSC_358, STD_NTSC_443: begin
                rt_ry = sat_neg(in_ry);
                rt_by = sat_neg(in_by);
            end
            default: begin
                rt_ry = BLACK;
                rt_by = BLACK;
            end
        endcase
    end

endmodule

// File: rtl/blank_out_reg.sv
module blank_out_reg #(
    parameter int DATA_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic                     hblank,
    input  logic                     hvblank,
    input  logic                     colour_en,
    input  logic signed [DATA_W-1:0] rt_ry,
    input  logic signed [DATA_W-1:0] rt_by,
    output logic signed [DATA_W-1:0] out_ry,
    output logic signed [DATA_W-1:0] out_by,
    output logic                     out_valid
);

    logic force_black;
    assign force_black = hblank | hvblank | ~colour_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ry    <= '0;
            out_by    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) begin
                out_ry <= force_black ? '0 : rt_ry;
                out_by <= force_black ? '0 : rt_by;
            end
        end
    end

    // R7: flyback blanking reaches the outputs one clock later
    p_flyback_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (hblank || hvblank)) |=> (out_ry == '0 && out_by == '0));

    // R8: colour killer blacks both outputs
    p_kill_black_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !colour_en) |=> (out_ry == '0 && out_by == '0));

    // R10: without a valid sample the outputs hold
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(out_ry) && $stable(out_by) && !out_valid));

endmodule

// File: rtl/chroma_alt_blank.sv
module chroma_alt_blank
    import chroma_alt_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic                     line_start,
    input  logic                     hblank,
    input  logic                     hvblank,
    input  logic [1:0]               std_mode,
    input  logic                     colour_en,
    input  logic                     phase_err,
    input  logic signed [DATA_W-1:0] in_ry,
    input  logic signed [DATA_W-1:0] in_by,
    output logic signed [DATA_W-1:0] out_ry,
    output logic signed [DATA_W-1:0] out_by,
    output logic                     out_valid,
    output logic                     pal_invert
);

    logic                     by_line;
    logic                     fix_pending;
    logic signed [DATA_W-1:0] rt_ry;
    logic signed [DATA_W-1:0] rt_by;

    h2_phase_fsm u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .phase_err   (phase_err),
        .by_line     (by_line),
        .fix_pending (fix_pending)
    );

    chroma_route #(.DATA_W(DATA_W)) u_route (
        .std_mode   (std_mode),
        .by_line    (by_line),
        .in_ry      (in_ry),
        .in_by      (in_by),
        .rt_ry      (rt_ry),
        .rt_by      (rt_by),
        .pal_invert (pal_invert)
    );

    blank_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .hblank    (hblank),
        .hvblank   (hvblank),
        .colour_en (colour_en),
        .rt_ry     (rt_ry),
        .rt_by     (rt_by),
        .out_ry    (out_ry),
        .out_by    (out_by),
        .out_valid (out_valid)
    );

    // R4: in sequential mode at most one channel carries colour
    p_secam_one_channel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && std_mode == 2'b01) |=> (out_ry == '0 || out_by == '0));

    // R6: the line switch never engages in either NTSC mode
    p_ntsc_no_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        std_mode[1] |-> !pal_invert);

    // R1: outputs are quiet in the cycle after a reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_ry == '0 && out_by == '0));

endmodule

// File: tb/chroma_alt_blank_tb.sv
module chroma_alt_blank_tb;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n, smp_valid, line_start, hblank, hvblank, colour_en, phase_err;
    logic [1:0] std_mode;
    logic signed [W-1:0] in_ry, in_by;
    logic signed [W-1:0] out_ry, out_by;
    logic out_valid, pal_invert;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    chroma_alt_blank #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .line_start(line_start),
        .hblank(hblank), .hvblank(hvblank), .std_mode(std_mode),
        .colour_en(colour_en), .phase_err(phase_err),
        .in_ry(in_ry), .in_by(in_by),
        .out_ry(out_ry), .out_by(out_by), .out_valid(out_valid),
        .pal_invert(pal_invert)
    );

    // fields: mode[37:36] ls[35] hb[34] vb[33] en[32] ry[31:24] by[23:16] ery[15:8] eby[7:0]
    localparam int NV = 12;
    localparam logic [37:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1,  8'sd20,  -8'sd30, -8'sd20,   8'sd30},  // R5 R-Y line
        {2'd0, 1'b1, 1'b0, 1'b0, 1'b1,  8'sd20,  -8'sd30,  8'sd20,   8'sd30},  // R5 B-Y line
        {2'd1, 1'b1, 1'b0, 1'b0, 1'b1,  8'sd40,   8'sd99, -8'sd40,   8'sd0},   // R4 R-Y line
        {2'd1, 1'b1, 1'b0, 1'b0, 1'b1,  8'sd40,   8'sd99,  8'sd0,   -8'sd40},  // R4 B-Y line
        {2'd2, 1'b0, 1'b0, 1'b0, 1'b1,  8'sd10,   8'sd5,  -8'sd10,  -8'sd5},   // R6 on B-Y line
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, -8'sd7,    8'sd8,   8'sd7,   -8'sd8},   // R6
        {2'd0, 1'b0, 1'b1, 1'b0, 1'b1,  8'sd50,   8'sd60,  8'sd0,    8'sd0},   // R7 hblank
        {2'd1, 1'b1, 1'b0, 1'b1, 1'b1,  8'sd50,   8'sd60,  8'sd0,    8'sd0},   // R7 hvblank
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0,  8'sd33,   8'sd44,  8'sd0,    8'sd0},   // R8 kill
        {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, -8'sd128, -8'sd128, 8'sd127,  8'sd127}, // R9
        {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, -8'sd128,  8'sd127, -8'sd128, -8'sd127},// R9 pass on B-Y line
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, -8'sd128,  8'sd3,   8'sd0,    8'sd127}  // R9 sequential
    };

    function automatic string vtag(input int i);
        case (i)
            0, 1:    return "R5";
            2, 3:    return "R4";
            4, 5:    return "R6";
            6, 7:    return "R7";
            8:       return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        smp_valid = 0; line_start = 0; phase_err = 0;
        hblank = 0; hvblank = 0;
    endtask

    task automatic pulse_line(input logic err);
        line_start = 1; phase_err = err; smp_valid = 0;
        @(negedge clk);
        line_start = 0; phase_err = 0;
    endtask

    task automatic pulse_err();
        phase_err = 1;
        @(negedge clk);
        phase_err = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; idle(); colour_en = 0; std_mode = 2'd0; in_ry = 0; in_by = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_ry", int'(out_ry), 0);
        check("R1 out_by", int'(out_by), 0);
        check("R1 pal_invert", int'(pal_invert), 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            std_mode = VEC[i][37:36];
            if (VEC[i][35]) pulse_line(1'b0);
            hblank = VEC[i][34]; hvblank = VEC[i][33]; colour_en = VEC[i][32];
            in_ry = VEC[i][31:24]; in_by = VEC[i][23:16];
            smp_valid = 1;
            @(negedge clk);
            check({vtag(i), " out_ry"}, int'(out_ry), int'($signed(VEC[i][15:8])));
            check({vtag(i), " out_by"}, int'(out_by), int'($signed(VEC[i][7:0])));
            check("R10 out_valid", int'(out_valid), 1);
            idle();
        end

        // R10: idle cycle holds data, drops valid
        in_ry = 8'sd77; in_by = 8'sd77;
        @(negedge clk);
        check("R10 hold out_valid", int'(out_valid), 0);
        check("R10 hold out_ry", int'(out_ry), 0);
        check("R10 hold out_by", int'(out_by), 127);

        // R3 and R2 via pal_invert in phase-alternating mode
        do_reset();
        rst_n = 1; colour_en = 1; std_mode = 2'd0;
        @(negedge clk);
        check("R1 phase after reset", int'(pal_invert), 0);
        pulse_line(1'b0);
        check("R2 toggle", int'(pal_invert), 1);
        @(negedge clk);
        check("R2 stable midline", int'(pal_invert), 1);
        pulse_err();
        pulse_err();
        check("R3 no midline move", int'(pal_invert), 1);
        pulse_line(1'b0);
        check("R3 slip holds phase", int'(pal_invert), 1);
        pulse_line(1'b0);
        check("R3 fix cleared", int'(pal_invert), 0);
        pulse_line(1'b1);
        check("R3 err at line start toggles", int'(pal_invert), 1);
        pulse_line(1'b0);
        check("R3 fix armed at line start", int'(pal_invert), 1);

        // R6: NTSC never inverts even on a B-Y line
        std_mode = 2'd2;
        #1;
        check("R6 pal_invert ntsc", int'(pal_invert), 0);
        std_mode = 2'd3;
        #1;
        check("R6 pal_invert ntsc443", int'(pal_invert), 0);

        // R2: sample on the line-start cycle uses old phase (B-Y line, PAL)
        std_mode = 2'd0; @(negedge clk);
        line_start = 1; smp_valid = 1; in_ry = 8'sd15; in_by = 8'sd1;
        @(negedge clk);
        idle();
        check("R2 same-cycle sample old phase", int'(out_ry), 15);
        check("R2 new phase", int'(pal_invert), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule